// File: doc/BRIEF.md
# Fixed-Degree Sequential Prefetch Sequencer

This block drives next-block prefetching for a second-level cache. When the cache reports a read miss on block n, the sequencer first sends the demand read for n. It then walks the following blocks n+1, n+2, ... up to n+K, where K is the prefetch degree. It handles one candidate per cache cycle. For each candidate it drives a tag lookup and a query to the outstanding-request buffer. It sends a prefetch request only when the block is neither resident nor already outstanding.

Memory answers a prefetch in one of two ways: a data reply that carries the block, or a negative reply saying the block was in transit and cannot be supplied. Data replies become fill commands for the cache. A prefetched fill carries a marker. A negative reply fills nothing. The processor is held only until its own demand block returns, so the prefetch walk runs in the shadow of that miss. A new miss during a walk cancels the candidates that remain and starts a fresh sequence.

Top module: `seqpf_engine`

## Requirements
- R1: While reset is held and on the first cycle after it, `rq_vld`, `lk_vld`, `fill_vld` and `stall` are all 0.
- R2: A miss sampled on a clock edge makes `rq_vld`=1, `rq_kind`=0 (demand) and `rq_addr`=miss block in the following cycle, and `stall`=1 from that cycle on.
- R3: After a miss with degree K>0, `lk_vld` is 1 for exactly K consecutive cycles, starting the cycle after the miss. During those cycles `lk_addr` and `pq_addr` step through n+1, n+2, ... n+K, one per cycle.
- R4: A candidate looked up in cycle t produces `rq_vld`=1, `rq_kind`=1 (prefetch) and `rq_addr`=candidate in cycle t+1, but only if `lk_hit`=0 and `pq_busy`=0 in cycle t. Otherwise `rq_vld` is 0 in cycle t+1.
- R5: A degree of 0 still issues the demand read but makes no lookup and no prefetch request.
- R6: A miss that arrives during a walk drops the candidate looked up in that cycle and all later ones. The new demand goes out next, and the walk restarts from the new block with the degree sampled at that miss.
- R7: `stall` falls in the cycle after a demand-data reply (`rp_kind`=00) whose address equals the last missed block. Prefetch replies and the walk itself leave `stall` unchanged.
- R8: One cycle after a reply, the fill port reacts as follows. Demand data (00) gives `fill_vld`=1 with `fill_pf`=0. Prefetch data (01) gives `fill_vld`=1 with `fill_pf`=1. A negative reply (10) or the reserved code (11) gives `fill_vld`=0. `fill_addr` equals `rp_addr`.
- R9: Candidate addresses wrap modulo 2^ADDR_W, so block all-ones is followed by block 0.
- R10: With no miss, no request and no lookup are ever made, whatever the lookup inputs show.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cache clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_vld | input | 1 | Read miss in the second-level cache this cycle |
| miss_addr | input | ADDR_W | Block address of the miss |
| degree | input | DEG_W | Prefetch degree K, sampled with the miss; 0 turns the walk off |
| lk_vld | output | 1 | Candidate tag lookup active |
| lk_addr | output | ADDR_W | Candidate block address for the tag lookup |
| lk_hit | input | 1 | Candidate is resident (same cycle) |
| pq_addr | output | ADDR_W | Candidate block address for the pending query |
| pq_busy | input | 1 | Candidate already has an outstanding request (same cycle) |
| rq_vld | output | 1 | Request to memory valid |
| rq_kind | output | 1 | 0 demand read, 1 prefetch |
| rq_addr | output | ADDR_W | Requested block address |
| rp_vld | input | 1 | Reply from memory valid |
| rp_kind | input | 2 | 00 demand data, 01 prefetch data, 10 prefetch negative, 11 reserved |
| rp_addr | input | ADDR_W | Block address of the reply |
| fill_vld | output | 1 | Install a block in the cache |
| fill_addr | output | ADDR_W | Block address to install |
| fill_pf | output | 1 | Installed block came from a prefetch |
| stall | output | 1 | Processor held for the demand miss |

## Verification
A miss sampled on edge E shows up at the request port one cycle later. The lookup for candidate i is visible i cycles after E, and its prefetch request one cycle after that. Fill and stall changes appear one cycle after the reply that causes them. The bench drives inputs on the falling edge and reads results on the falling edge that follows each such register stage. It walks candidate i and the request for candidate i-1 in the same sampling step, so every check lands on the cycle its requirement names.

// File: rtl/seqpf_pkg.sv
package seqpf_pkg;

  typedef enum logic {
    RQ_DEMAND   = 1'b0,
    RQ_PREFETCH = 1'b1
  } rq_kind_e;

  typedef enum logic [1:0] {
    RP_DEM_DATA = 2'b00,
    RP_PF_DATA  = 2'b01,
    RP_PF_NEG   = 2'b10,
    RP_RSVD     = 2'b11
  } rp_kind_e;

  // a reply carries a block only for the two data codes
  function automatic logic reply_fills(input logic [1:0] k);
    return (k == RP_DEM_DATA) || (k == RP_PF_DATA);
  endfunction

endpackage

// File: rtl/seqpf_walker.sv
module seqpf_walker
  import seqpf_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int MAX_DEG = 7,
  parameter int DEG_W   = $clog2(MAX_DEG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DEG_W-1:0]  start_deg,
  output logic              lk_vld,
  output logic [ADDR_W-1:0] lk_addr
);

  localparam logic [DEG_W-1:0] DEG_CAP = DEG_W'(MAX_DEG);
  localparam logic [DEG_W-1:0] DEG_ONE = DEG_W'(1);

  // next block, modulo the block address space
  function automatic logic [ADDR_W-1:0] step_blk(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic [DEG_W-1:0] cap_deg(input logic [DEG_W-1:0] d);
    return (d > DEG_CAP) ? DEG_CAP : d;
  endfunction

  logic [ADDR_W-1:0] cand_q;
  logic [DEG_W-1:0]  left_q;
  logic              walk_q;
  logic [DEG_W-1:0]  deg_eff;

  assign deg_eff = cap_deg(start_deg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cand_q <= '0;
      left_q <= '0;
      walk_q <= 1'b0;
    end else if (start) begin
      cand_q <= step_blk(start_addr);
      left_q <= deg_eff;
      walk_q <= (deg_eff != '0);
    end else if (walk_q) begin
      cand_q <= step_blk(cand_q);
      left_q <= left_q - DEG_ONE;
      walk_q <= (left_q != DEG_ONE);
    end
  end

  assign lk_vld  = walk_q;
  assign lk_addr = cand_q;

  AST_LOOKUP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_vld && $past(lk_vld) && !$past(start)) |-> (lk_addr == $past(lk_addr) + ADDR_W'(1))); // R3

  AST_RESTART_AT_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!lk_vld || lk_addr == $past(start_addr) + ADDR_W'(1))); // R6

  AST_ZERO_DEG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_deg == '0) |=> !lk_vld); // R5

endmodule

// File: rtl/seqpf_issue.sv
module seqpf_issue
  import seqpf_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_vld,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic              lk_vld,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_hit,
  input  logic              pq_busy,
  output logic              rq_vld,
  output logic              rq_kind,
  output logic [ADDR_W-1:0] rq_addr
);

  // named events for the checks below
  logic ev_cand_free;
  logic ev_pf_issue;
  logic ev_pf_drop;

  assign ev_cand_free = lk_vld && !lk_hit && !pq_busy;
  assign ev_pf_issue  = ev_cand_free && !miss_vld;
  assign ev_pf_drop   = lk_vld && miss_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rq_vld  <= 1'b0;
      rq_kind <= RQ_DEMAND;
      rq_addr <= '0;
    end else if (miss_vld) begin
      rq_vld  <= 1'b1;
      rq_kind <= RQ_DEMAND;
      rq_addr <= miss_addr;
    end else if (ev_pf_issue) begin
      rq_vld  <= 1'b1;
      rq_kind <= RQ_PREFETCH;
      rq_addr <= lk_addr;
    end else begin
      rq_vld  <= 1'b0;
    end
  end

  AST_DEMAND_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    miss_vld |=> (rq_vld && rq_kind == RQ_DEMAND && rq_addr == $past(miss_addr))); // R2

  AST_PF_FILTERED: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_vld && rq_kind == RQ_PREFETCH) |-> $past(lk_vld && !lk_hit && !pq_busy)); // R4

  AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
    rq_vld |-> $past(miss_vld || lk_vld)); // R10

  AST_ABORT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pf_drop |=> (rq_kind == RQ_DEMAND)); // R6

endmodule

// File: rtl/seqpf_reply.sv
module seqpf_reply
  import seqpf_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_vld,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic              rp_vld,
  input  logic [1:0]        rp_kind,
  input  logic [ADDR_W-1:0] rp_addr,
  output logic              stall,
  output logic              fill_vld,
  output logic [ADDR_W-1:0] fill_addr,
  output logic              fill_pf
);

  logic [ADDR_W-1:0] dem_addr_q;
  logic              ev_dem_back;

  assign ev_dem_back = rp_vld && (rp_kind == RP_DEM_DATA) && (rp_addr == dem_addr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stall      <= 1'b0;
      dem_addr_q <= '0;
    end else if (miss_vld) begin
      stall      <= 1'b1;
      dem_addr_q <= miss_addr;
    end else if (ev_dem_back) begin
      stall      <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_vld  <= 1'b0;
      fill_addr <= '0;
      fill_pf   <= 1'b0;
    end else begin
      fill_vld  <= rp_vld && reply_fills(rp_kind);
      fill_addr <= rp_addr;
      fill_pf   <= (rp_kind == RP_PF_DATA);
    end
  end

  AST_NEG_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (rp_vld && rp_kind == RP_PF_NEG) |=> !fill_vld); // R8

  AST_STALL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> $past(rp_vld && rp_kind == RP_DEM_DATA)); // R7

  AST_STALL_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    miss_vld |=> stall); // R2

endmodule

// File: rtl/seqpf_engine.sv
module seqpf_engine
  import seqpf_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int MAX_DEG = 7,
  localparam int DEG_W  = $clog2(MAX_DEG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_vld,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic [DEG_W-1:0]  degree,
  output logic              lk_vld,
  output logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_hit,
  output logic [ADDR_W-1:0] pq_addr,
  input  logic              pq_busy,
  output logic              rq_vld,
  output logic              rq_kind,
  output logic [ADDR_W-1:0] rq_addr,
  input  logic              rp_vld,
  input  logic [1:0]        rp_kind,
  input  logic [ADDR_W-1:0] rp_addr,
  output logic              fill_vld,
  output logic [ADDR_W-1:0] fill_addr,
  output logic              fill_pf,
  output logic              stall
);

  logic              walk_vld;
  logic [ADDR_W-1:0] walk_addr;

  seqpf_walker #(.ADDR_W(ADDR_W), .MAX_DEG(MAX_DEG), .DEG_W(DEG_W)) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (miss_vld),
    .start_addr (miss_addr),
    .start_deg  (degree),
    .lk_vld     (walk_vld),
    .lk_addr    (walk_addr)
  );

  assign lk_vld  = walk_vld;
  assign lk_addr = walk_addr;
  assign pq_addr = walk_addr;

  seqpf_issue #(.ADDR_W(ADDR_W)) u_issue (
    .clk       (clk),
    .rst_n     (rst_n),
    .miss_vld  (miss_vld),
    .miss_addr (miss_addr),
    .lk_vld    (walk_vld),
    .lk_addr   (walk_addr),
    .lk_hit    (lk_hit),
    .pq_busy   (pq_busy),
    .rq_vld    (rq_vld),
    .rq_kind   (rq_kind),
    .rq_addr   (rq_addr)
  );

  seqpf_reply #(.ADDR_W(ADDR_W)) u_reply (
    .clk       (clk),
    .rst_n     (rst_n),
    .miss_vld  (miss_vld),
    .miss_addr (miss_addr),
    .rp_vld    (rp_vld),
    .rp_kind   (rp_kind),
    .rp_addr   (rp_addr),
    .stall     (stall),
    .fill_vld  (fill_vld),
    .fill_addr (fill_addr),
    .fill_pf   (fill_pf)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(!rst_n) |-> (!rq_vld && !lk_vld && !fill_vld && !stall)); // R1

endmodule

// File: tb/sim_seqpf_engine.sv
module sim_seqpf_engine;

  localparam int AW = 16;
  localparam int DW = 3;
  localparam int NV = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          miss_vld = 1'b0;
  logic [AW-1:0] miss_addr = '0;
  logic [DW-1:0] degree = '0;
  logic          lk_vld, lk_hit;
  logic [AW-1:0] lk_addr, pq_addr;
  logic          pq_busy;
  logic          rq_vld, rq_kind;
  logic [AW-1:0] rq_addr;
  logic          rp_vld = 1'b0;
  logic [1:0]    rp_kind = 2'b00;
  logic [AW-1:0] rp_addr = '0;
  logic          fill_vld, fill_pf, stall;
  logic [AW-1:0] fill_addr;

  // stubs: residency and pending state keyed by low nibble of the block
  logic [15:0] hit_mask  = '0;
  logic [15:0] busy_mask = '0;
  assign lk_hit  = lk_vld & hit_mask[lk_addr[3:0]];
  assign pq_busy = lk_vld & busy_mask[pq_addr[3:0]];

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  seqpf_engine #(.ADDR_W(AW), .MAX_DEG(7)) u0 (
    .clk(clk), .rst_n(rst_n), .miss_vld(miss_vld), .miss_addr(miss_addr),
    .degree(degree), .lk_vld(lk_vld), .lk_addr(lk_addr), .lk_hit(lk_hit),
    .pq_addr(pq_addr), .pq_busy(pq_busy), .rq_vld(rq_vld), .rq_kind(rq_kind),
    .rq_addr(rq_addr), .rp_vld(rp_vld), .rp_kind(rp_kind), .rp_addr(rp_addr),
    .fill_vld(fill_vld), .fill_addr(fill_addr), .fill_pf(fill_pf), .stall(stall)
  );

  // {miss block, degree, hit mask, busy mask}
  localparam logic [50:0] VEC [NV] = '{
    {16'h0010, 3'd3, 16'h0000, 16'h0000},
    {16'h0020, 3'd4, 16'h0004, 16'h0008},
    {16'h0030, 3'd0, 16'h0000, 16'h0000},
    {16'h0005, 3'd7, 16'h00C0, 16'h1000},
    {16'h0100, 3'd1, 16'h0002, 16'h0000},
    {16'hFFFE, 3'd3, 16'h0000, 16'h0001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_rq(input string req, input logic v, input logic k, input logic [AW-1:0] a);
    check(req, {31'd0, rq_vld}, {31'd0, v});
    if (v) begin
      check(req, {31'd0, rq_kind}, {31'd0, k});
      check(req, {16'd0, rq_addr}, {16'd0, a});
    end
  endtask

  // drive a miss, then follow lookups and requests cycle by cycle
  task automatic run_walk(input logic [AW-1:0] n, input logic [DW-1:0] k);
    logic [AW-1:0] prev_c;
    logic          prev_go;
    @(negedge clk);
    miss_vld  = 1'b1;
    miss_addr = n;
    degree    = k;
    prev_c  = '0;
    prev_go = 1'b0;
    for (int i = 1; i <= int'(k) + 1; i++) begin
      logic [AW-1:0] c;
      @(negedge clk);
      miss_vld = 1'b0;
      if (i == 1) begin
        check_rq("R2 demand", 1'b1, 1'b0, n);
        check("R2 stall", {31'd0, stall}, 32'd1);
      end else begin
        check_rq("R4 prefetch filter", prev_go, 1'b1, prev_c);
      end
      c = n + AW'(i);  // R9 wraps modulo 2^16
      if (i <= int'(k)) begin
        check("R3 lookup valid", {31'd0, lk_vld}, 32'd1);
        check("R3 R9 lookup addr", {16'd0, lk_addr}, {16'd0, c});
        check("R3 pending addr", {16'd0, pq_addr}, {16'd0, c});
        prev_c  = c;
        prev_go = !hit_mask[c[3:0]] && !busy_mask[c[3:0]];
      end else begin
        check("R3 R5 lookup ends", {31'd0, lk_vld}, 32'd0);
      end
    end
    @(negedge clk);
    check("R3 R5 walk idle", {31'd0, lk_vld}, 32'd0);
    check("R4 R5 no extra request", {31'd0, rq_vld}, 32'd0);
  endtask

  task automatic send_reply(input logic [1:0] kd, input logic [AW-1:0] a);
    @(negedge clk);
    rp_vld  = 1'b1;
    rp_kind = kd;
    rp_addr = a;
    @(negedge clk);
    rp_vld  = 1'b0;
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 rq in reset", {31'd0, rq_vld}, 32'd0);
    check("R1 lk in reset", {31'd0, lk_vld}, 32'd0);
    check("R1 stall in reset", {31'd0, stall}, 32'd0);
    check("R1 fill in reset", {31'd0, fill_vld}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rq after reset", {31'd0, rq_vld}, 32'd0);
    check("R1 stall after reset", {31'd0, stall}, 32'd0);

    // R10 no miss, nothing happens
    hit_mask = '0;
    busy_mask = '0;
    repeat (4) begin
      @(negedge clk);
      check("R10 idle rq", {31'd0, rq_vld}, 32'd0);
      check("R10 idle lk", {31'd0, lk_vld}, 32'd0);
    end

    // table of walks (R2..R5, R9)
    for (int v = 0; v < NV; v++) begin
      hit_mask  = VEC[v][31:16];
      busy_mask = VEC[v][15:0];
      run_walk(VEC[v][50:35], VEC[v][34:32]);
    end

    // R6 abort: walk from 0x40 degree 5, new miss 0x80 degree 2 during the second lookup
    hit_mask  = '0;
    busy_mask = '0;
    @(negedge clk);
    miss_vld = 1'b1; miss_addr = 16'h0040; degree = 3'd5;
    @(negedge clk);
    miss_vld = 1'b0;
    check_rq("R6 first demand", 1'b1, 1'b0, 16'h0040);
    check("R6 first lookup", {16'd0, lk_addr}, 32'h41);
    @(negedge clk);
    check_rq("R6 first prefetch", 1'b1, 1'b1, 16'h0041);
    check("R6 second lookup", {16'd0, lk_addr}, 32'h42);
    miss_vld = 1'b1; miss_addr = 16'h0080; degree = 3'd2;
    @(negedge clk);
    miss_vld = 1'b0;
    check_rq("R6 new demand wins", 1'b1, 1'b0, 16'h0080);
    check("R6 restart lookup", {16'd0, lk_addr}, 32'h81);
    @(negedge clk);
    check_rq("R6 new prefetch 1", 1'b1, 1'b1, 16'h0081);
    check("R6 restart lookup 2", {16'd0, lk_addr}, 32'h82);
    @(negedge clk);
    check_rq("R6 new prefetch 2", 1'b1, 1'b1, 16'h0082);
    check("R6 walk over", {31'd0, lk_vld}, 32'd0);
    @(negedge clk);
    check("R6 no stale prefetch", {31'd0, rq_vld}, 32'd0);
    check("R7 stall held over walk", {31'd0, stall}, 32'd1);

    // R7 / R8 replies; last demand is 0x80
    send_reply(2'b01, 16'h0081);
    check("R8 pf data fill", {31'd0, fill_vld}, 32'd1);
    check("R8 pf marker", {31'd0, fill_pf}, 32'd1);
    check("R8 pf fill addr", {16'd0, fill_addr}, 32'h81);
    check("R7 pf reply keeps stall", {31'd0, stall}, 32'd1);
    send_reply(2'b10, 16'h0082);
    check("R8 negative no fill", {31'd0, fill_vld}, 32'd0);
    check("R7 negative keeps stall", {31'd0, stall}, 32'd1);
    send_reply(2'b11, 16'h0083);
    check("R8 reserved no fill", {31'd0, fill_vld}, 32'd0);
    send_reply(2'b00, 16'h0090);
    check("R7 wrong demand addr keeps stall", {31'd0, stall}, 32'd1);
    send_reply(2'b00, 16'h0080);
    check("R8 demand fill", {31'd0, fill_vld}, 32'd1);
    check("R8 demand marker", {31'd0, fill_pf}, 32'd0);
    check("R8 demand fill addr", {16'd0, fill_addr}, 32'h80);
    check("R7 stall released", {31'd0, stall}, 32'd0);
    @(negedge clk);
    check("R8 fill one cycle", {31'd0, fill_vld}, 32'd0);
    check("R7 stall stays low", {31'd0, stall}, 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule